// File: doc/BRIEF.md
# Decode-Execute Stall Controller

This block is the sequencing logic of the decode/execute stage in a two-stage, in-order processor. Each cycle it looks at the class of the instruction held in the stage. The class arrives already decoded. The block then decides whether that instruction finishes this cycle or holds the stage. While an instruction holds the stage it raises `stall`, so the fetch stage keeps the next instruction back. When the instruction finishes, the block raises `retire` for that one cycle.

Each class has its own hold rule. Integer and CSR instructions finish at once, and so does a branch whose condition is false. Loads and stores wait for the data-memory response. A returning load writes the register file in the cycle its data arrives. Multiply and divide wait for the arithmetic unit's done flag. Jumps and FENCE.I redirect fetch and then wait for the fetch side to deliver the new instruction. A taken branch first spends one cycle on its condition and a second cycle on its target, then acts as a jump. When the parameter `BRANCH_TGT_ADDER` is non-zero, a separate adder computes the target in parallel, which removes one cycle.

The ALU, the decoder, the prefetch buffer and the memories are outside this block.

Top module: `dx_stall_ctrl`

## Requirements
- R1: During reset and after it, no output is asserted while `id_valid` is low, whatever the response inputs do. Reset abandons any instruction in flight and returns the stage to its issue phase.
- R2: Class codes 0 (integer) and 1 (CSR) finish in their issue cycle with zero stall cycles. Unused codes 9 to 15 are treated the same way.
- R3: Class codes 2 (load) and 3 (store) stall for at least one cycle. They stall until `dmem_rvalid` is high in a cycle after the issue cycle. A response present in the issue cycle is ignored.
- R4: `rf_load_we` is high only in the cycle a load's response arrives, and only if `dmem_err` is low in that cycle. A store never raises it.
- R5: Class codes 4 (multiply) and 5 (divide) stall until `md_done` is high. If `md_done` is already high in the issue cycle, the instruction finishes with zero stall cycles.
- R6: Class codes 6 (jump) and 8 (FENCE.I) raise `fetch_redirect` for exactly one cycle, which is their issue cycle. They stall until `fetch_valid` is high in a later cycle, so they always stall at least one cycle.
- R7: Class code 7 (branch) with `br_taken` low finishes in its issue cycle without a stall or a redirect.
- R8: A taken branch with `BRANCH_TGT_ADDER` = 0 stalls in its issue cycle and redirects in the next cycle, then waits as a jump does (at least 2 stalls). With a non-zero parameter it redirects in its issue cycle (at least 1 stall).
- R9: `retire` fires exactly once per instruction, in its final cycle in the stage. `stall` is low in that cycle, and `stall` is high in every earlier cycle of that instruction.
- R10: `id_class` and `br_taken` are sampled only in the issue cycle. Changes to them while the instruction is stalled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | An instruction occupies the stage this cycle |
| id_class | input | 4 | Decoded instruction class code (see R2 to R8) |
| br_taken | input | 1 | Branch condition result for a branch in its issue cycle |
| dmem_rvalid | input | 1 | Data-memory response present |
| dmem_err | input | 1 | Data-memory response reports an error |
| md_done | input | 1 | Multiply/divide unit has its result |
| fetch_valid | input | 1 | Fetch side presents an instruction after a redirect |
| stall | output | 1 | Stage is held; upstream keeps its instruction |
| fetch_redirect | output | 1 | Flush fetch and request the new PC (one-cycle pulse) |
| rf_load_we | output | 1 | Register-file write enable for returning load data |
| retire | output | 1 | Instruction completes this cycle |

## Verification
Every output depends combinationally on the registered phase and the current inputs. So the effect of a response shows up in the same cycle the response is driven, and the next phase takes effect after one clock edge. The bench sets inputs on the falling edge and samples one nanosecond later, and it counts stall cycles from the issue cycle until `stall` drops.

The bench models fetch and memory latency as a per-vector delay. It releases `fetch_valid` a set number of cycles after the observed redirect, and it releases `dmem_rvalid` or `md_done` a set number of cycles after issue. For each class it then compares the stall count, the redirect cycle, the number of retires and the number of load writes against the formula for that class.

// File: rtl/dx_stall_pkg.sv
package dx_stall_pkg;

  localparam int unsigned CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    IC_INT    = 4'd0,
    IC_CSR    = 4'd1,
    IC_LOAD   = 4'd2,
    IC_STORE  = 4'd3,
    IC_MUL    = 4'd4,
    IC_DIV    = 4'd5,
    IC_JUMP   = 4'd6,
    IC_BRANCH = 4'd7,
    IC_FENCEI = 4'd8
  } iclass_e;

  typedef enum logic [2:0] {
    PH_ISSUE = 3'd0,
    PH_MEM   = 3'd1,
    PH_MD    = 3'd2,
    PH_TGT   = 3'd3,
    PH_FETCH = 3'd4
  } phase_e;

  // What the issue cycle needs to know about an instruction
  typedef struct packed {
    logic mem;   // waits on the data-memory response
    logic load;  // response carries register data
    logic md;    // waits on the multiply/divide unit
    logic jmp;   // redirects fetch unconditionally
    logic br;    // conditional redirect
  } kind_t;

endpackage

// File: rtl/dx_class_decode.sv
module dx_class_decode
  import dx_stall_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output kind_t            kind
);

  always_comb begin
    kind = '0;
    case (iclass_e'(cls))
      IC_LOAD:   begin kind.mem = 1'b1; kind.load = 1'b1; end
      IC_STORE:  kind.mem = 1'b1;
      IC_MUL,
      IC_DIV:    kind.md  = 1'b1;
      IC_JUMP,
      IC_FENCEI: kind.jmp = 1'b1;
      IC_BRANCH: kind.br  = 1'b1;
      default:   kind = '0;  // integer, CSR and unused codes finish at once
    endcase
  end

endmodule

// File: rtl/dx_phase_reg.sv
module dx_phase_reg
  import dx_stall_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e nxt_phase,
  input  logic   capture,
  input  logic   load_in,
  output phase_e phase,
  output logic   held_load
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_ISSUE;
      held_load <= 1'b0;
    end else begin
      phase <= nxt_phase;
      if (capture) held_load <= load_in;
    end
  end

endmodule

// File: rtl/dx_step_logic.sv
module dx_step_logic
  import dx_stall_pkg::*;
#(
  parameter int unsigned BRANCH_TGT_ADDER = 0
) (
  input  phase_e phase,
  input  logic   held_load,
  input  logic   id_valid,
  input  kind_t  kind,
  input  logic   br_taken,
  input  logic   dmem_rvalid,
  input  logic   dmem_err,
  input  logic   md_done,
  input  logic   fetch_valid,
  output phase_e nxt_phase,
  output logic   capture,
  output logic   done,
  output logic   redirect,
  output logic   ld_we,
  output logic   stall
);

  // Whether a taken branch redirects in its issue cycle
  logic tgt_now;

  generate
    if (BRANCH_TGT_ADDER != 0) begin : g_tgt_adder
      assign tgt_now = 1'b1;
    end else begin : g_tgt_shared_alu
      assign tgt_now = 1'b0;
    end
  endgenerate

  logic issuing;
  assign issuing = (phase == PH_ISSUE) && id_valid;
  assign capture = issuing;

  always_comb begin
    nxt_phase = phase;
    done      = 1'b0;
    redirect  = 1'b0;
    ld_we     = 1'b0;
    case (phase)
      PH_ISSUE: begin
        if (id_valid) begin
          if (kind.mem) begin
            nxt_phase = PH_MEM;
          end else if (kind.md) begin
            if (md_done) done = 1'b1;
            else         nxt_phase = PH_MD;
          end else if (kind.jmp) begin
            redirect  = 1'b1;
            nxt_phase = PH_FETCH;
          end else if (kind.br && br_taken) begin
            if (tgt_now) begin
              redirect  = 1'b1;
              nxt_phase = PH_FETCH;
            end else begin
              nxt_phase = PH_TGT;
            end
          end else begin
            done = 1'b1;
          end
        end
      end
      PH_MEM: begin
        if (dmem_rvalid) begin
          done  = 1'b1;
          ld_we = held_load & ~dmem_err;
        end
      end
      PH_MD: begin
        if (md_done) done = 1'b1;
      end
      PH_TGT: begin
        redirect  = 1'b1;
        nxt_phase = PH_FETCH;
      end
      PH_FETCH: begin
        if (fetch_valid) done = 1'b1;
      end
      default: nxt_phase = PH_ISSUE;
    endcase
    if (done) nxt_phase = PH_ISSUE;
  end

  assign stall = ((phase != PH_ISSUE) || id_valid) && !done;

endmodule

// File: rtl/dx_stall_ctrl.sv
module dx_stall_ctrl
  import dx_stall_pkg::*;
#(
  parameter int unsigned BRANCH_TGT_ADDER = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [CLS_W-1:0] id_class,
  input  logic             br_taken,
  input  logic             dmem_rvalid,
  input  logic             dmem_err,
  input  logic             md_done,
  input  logic             fetch_valid,
  output logic             stall,
  output logic             fetch_redirect,
  output logic             rf_load_we,
  output logic             retire
);

  kind_t  kind;
  phase_e phase;
  phase_e nxt_phase;
  logic   held_load;
  logic   capture;
  logic   done;

  dx_class_decode u_decode (
    .cls  (id_class),
    .kind (kind)
  );

  dx_step_logic #(
    .BRANCH_TGT_ADDER (BRANCH_TGT_ADDER)
  ) u_step (
    .phase       (phase),
    .held_load   (held_load),
    .id_valid    (id_valid),
    .kind        (kind),
    .br_taken    (br_taken),
    .dmem_rvalid (dmem_rvalid),
    .dmem_err    (dmem_err),
    .md_done     (md_done),
    .fetch_valid (fetch_valid),
    .nxt_phase   (nxt_phase),
    .capture     (capture),
    .done        (done),
    .redirect    (fetch_redirect),
    .ld_we       (rf_load_we),
    .stall       (stall)
  );

  dx_phase_reg u_phase (
    .clk       (clk),
    .rst       (rst),
    .nxt_phase (nxt_phase),
    .capture   (capture),
    .load_in   (kind.load),
    .phase     (phase),
    .held_load (held_load)
  );

  assign retire = done;

endmodule

// File: rtl/dx_stall_ctrl_chk.sv
module dx_stall_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic id_valid,
  input logic dmem_rvalid,
  input logic dmem_err,
  input logic stall,
  input logic fetch_redirect,
  input logic rf_load_we,
  input logic retire
);

  // R9: the finishing cycle never holds the stage
  a_r9_retire_not_stalled: assert property (@(posedge clk) disable iff (rst)
    retire |-> !stall);

  // R4: a load write needs a clean response in the retiring cycle
  a_r4_load_write_on_response: assert property (@(posedge clk) disable iff (rst)
    rf_load_we |-> (retire && dmem_rvalid && !dmem_err));

  // R6: the redirect is a single-cycle pulse
  a_r6_redirect_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fetch_redirect |=> !fetch_redirect);

  // R6: a redirecting instruction is still in the stage
  a_r6_redirect_while_stalled: assert property (@(posedge clk) disable iff (rst)
    fetch_redirect |-> stall);

  // R1: an idle stage with nothing offered stays quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(stall) && !id_valid) |-> (!stall && !retire && !fetch_redirect && !rf_load_we));

endmodule

bind dx_stall_ctrl dx_stall_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .id_valid       (id_valid),
  .dmem_rvalid    (dmem_rvalid),
  .dmem_err       (dmem_err),
  .stall          (stall),
  .fetch_redirect (fetch_redirect),
  .rf_load_we     (rf_load_we),
  .retire         (retire)
);

// File: tb/dx_stall_ctrl_test.sv
module dx_stall_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       id_valid = 1'b0;
  logic [3:0] id_class = 4'd0;
  logic       br_taken = 1'b0;
  logic       dmem_rvalid = 1'b0;
  logic       dmem_err = 1'b0;
  logic       md_done = 1'b0;
  logic       fetch_valid = 1'b0;
  logic       sel_bta = 1'b0;

  logic s0, r0, w0, t0;
  logic s1, r1, w1, t1;
  logic stall, redir, ld_we, retire;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  dx_stall_ctrl #(.BRANCH_TGT_ADDER(0)) uut (
    .clk (clk), .rst (rst), .id_valid (id_valid & ~sel_bta), .id_class (id_class),
    .br_taken (br_taken), .dmem_rvalid (dmem_rvalid), .dmem_err (dmem_err),
    .md_done (md_done), .fetch_valid (fetch_valid),
    .stall (s0), .fetch_redirect (r0), .rf_load_we (w0), .retire (t0)
  );

  dx_stall_ctrl #(.BRANCH_TGT_ADDER(1)) uut_bta (
    .clk (clk), .rst (rst), .id_valid (id_valid & sel_bta), .id_class (id_class),
    .br_taken (br_taken), .dmem_rvalid (dmem_rvalid), .dmem_err (dmem_err),
    .md_done (md_done), .fetch_valid (fetch_valid),
    .stall (s1), .fetch_redirect (r1), .rf_load_we (w1), .retire (t1)
  );

  assign stall  = sel_bta ? s1 : s0;
  assign redir  = sel_bta ? r1 : r0;
  assign ld_we  = sel_bta ? w1 : w0;
  assign retire = sel_bta ? t1 : t0;

  typedef struct packed {
    logic [3:0] cls;
    logic       taken;
    logic       err;
    logic [3:0] lat;     // response delay in cycles
    logic       bta;     // 1: run on the target-adder instance
    logic [4:0] stalls;  // expected stall cycles
    logic [3:0] redir;   // expected redirect cycle index, 15 = none
    logic       we;      // expected load writes
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 4'd15, 1'b0},  // integer
    '{4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 4'd15, 1'b0},  // CSR
    '{4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 4'd15, 1'b0},  // branch not taken
    '{4'd2, 1'b0, 1'b0, 4'd3, 1'b0, 5'd3, 4'd15, 1'b1},  // load, 3-cycle memory
    '{4'd2, 1'b0, 1'b0, 4'd0, 1'b0, 5'd1, 4'd15, 1'b1},  // load, response already present
    '{4'd2, 1'b0, 1'b1, 4'd2, 1'b0, 5'd2, 4'd15, 1'b0},  // load with error
    '{4'd3, 1'b0, 1'b0, 4'd1, 1'b0, 5'd1, 4'd15, 1'b0},  // store
    '{4'd3, 1'b0, 1'b1, 4'd4, 1'b0, 5'd4, 4'd15, 1'b0},  // store with error
    '{4'd4, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 4'd15, 1'b0},  // multiply, done at once
    '{4'd4, 1'b0, 1'b0, 4'd3, 1'b0, 5'd3, 4'd15, 1'b0},  // multiply, 3 cycles
    '{4'd5, 1'b0, 1'b0, 4'd9, 1'b0, 5'd9, 4'd15, 1'b0},  // divide, 9 cycles
    '{4'd6, 1'b0, 1'b0, 4'd2, 1'b0, 5'd2, 4'd0,  1'b0},  // jump
    '{4'd6, 1'b0, 1'b0, 4'd0, 1'b0, 5'd1, 4'd0,  1'b0},  // jump, fetch already valid
    '{4'd8, 1'b0, 1'b0, 4'd3, 1'b0, 5'd3, 4'd0,  1'b0},  // FENCE.I
    '{4'd7, 1'b1, 1'b0, 4'd1, 1'b0, 5'd2, 4'd1,  1'b0},  // taken branch, shared ALU
    '{4'd7, 1'b1, 1'b0, 4'd0, 1'b0, 5'd2, 4'd1,  1'b0},  // taken, fetch already valid
    '{4'd7, 1'b1, 1'b0, 4'd3, 1'b0, 5'd4, 4'd1,  1'b0},  // taken, slow fetch
    '{4'd7, 1'b1, 1'b0, 4'd1, 1'b1, 5'd1, 4'd0,  1'b0},  // taken, target adder
    '{4'd7, 1'b1, 1'b0, 4'd4, 1'b1, 5'd4, 4'd0,  1'b0},  // taken, target adder, slow
    '{4'd7, 1'b0, 1'b0, 4'd0, 1'b1, 5'd0, 4'd15, 1'b0},  // not taken, target adder
    '{4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 5'd0, 4'd15, 1'b0},  // integer, target adder
    '{4'd6, 1'b0, 1'b0, 4'd2, 1'b1, 5'd2, 4'd0,  1'b0}   // jump, target adder
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string vreq(input vec_t v);
    case (v.cls)
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd8: return "R6";
      4'd7:       return v.taken ? "R8" : "R7";
      default:    return "R2";
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int  stalls = 0;
    int  redir_at = -1;
    int  n_redir = 0;
    int  n_ret = 0;
    int  n_we = 0;
    bit  fin = 1'b0;
    bit  last_ret = 1'b0;
    bit  is_ls = (v.cls == 4'd2) || (v.cls == 4'd3);
    bit  is_md = (v.cls == 4'd4) || (v.cls == 4'd5);
    bit  is_j  = (v.cls == 4'd6) || (v.cls == 4'd8) || ((v.cls == 4'd7) && v.taken);
    sel_bta = v.bta;
    for (int idx = 0; idx < 40 && !fin; idx++) begin
      id_valid = 1'b1;
      // R10: after issue, offer a different class and flipped condition
      id_class = (idx == 0) ? v.cls : 4'd0;
      br_taken = (idx == 0) ? v.taken : ~v.taken;
      dmem_err = v.err;
      dmem_rvalid = is_ls ? (idx >= int'(v.lat)) : 1'b1;
      md_done     = is_md ? (idx >= int'(v.lat)) : 1'b1;
      fetch_valid = is_j ? ((v.lat == 4'd0) || (redir_at >= 0 && idx >= redir_at + int'(v.lat))) : 1'b1;
      #1;
      if (stall) stalls++;
      if (redir) begin
        n_redir++;
        if (redir_at < 0) redir_at = idx;
      end
      if (retire) n_ret++;
      if (ld_we) n_we++;
      if (!stall) begin
        fin = 1'b1;
        last_ret = retire;
      end
      @(negedge clk);
    end
    id_valid = 1'b0;
    dmem_rvalid = 1'b0;
    md_done = 1'b0;
    fetch_valid = 1'b0;
    chk({vreq(v), "/R10"}, "stall cycles", stalls, int'(v.stalls));
    chk(vreq(v), "redirect cycle", redir_at, (v.redir == 4'd15) ? -1 : int'(v.redir));
    chk("R9", "retire count with retire in last cycle", last_ret ? n_ret : -1, 1);
    chk("R4", "load writes", n_we, int'(v.we));
    if (n_redir > 1) chk("R6", "redirect pulses", n_redir, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs quiet during reset
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "outputs in reset", {s0, r0, w0, t0, s1, r1, w1, t1}, 0);
    @(negedge clk);
    rst = 1'b0;
    // R1: responders active but nothing issued
    dmem_rvalid = 1'b1; md_done = 1'b1; fetch_valid = 1'b1; id_class = 4'd6; br_taken = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk("R1", "idle outputs with responses high", {s0, r0, w0, t0, s1, r1, w1, t1}, 0);
    end
    @(negedge clk);
    dmem_rvalid = 1'b0; md_done = 1'b0; fetch_valid = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: reset while a jump waits on fetch
    sel_bta = 1'b0;
    id_valid = 1'b1; id_class = 4'd6; br_taken = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R6", "jump still waiting before reset", stall, 1);
    id_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "stall after mid-instruction reset", stall, 0);
    chk("R1", "retire after mid-instruction reset", retire, 0);
    // R2: next instruction starts clean
    id_valid = 1'b1; id_class = 4'd0;
    #1;
    chk("R2", "integer after reset retires at once", {stall, retire}, 1);
    // R2: unused code acts as integer
    @(negedge clk);
    id_class = 4'd12;
    #1;
    chk("R2", "unused code retires at once", {stall, redir, retire}, 1);
    @(negedge clk);
    id_valid = 1'b0;
    #1;
    chk("R9", "no retire once the stage is empty", retire, 0);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule